// File: doc/BRIEF.md
# Microsecond Compare-Match System Timer

This block is a memory-mapped system timer. It keeps a 64-bit timestamp that counts up once per microsecond. A prescaler divides the fast system clock to make that rate. Software reaches the timer through a plain 32-bit register port with an address, a write strobe, write data, a read strobe and read data. Read data is registered: it appears on the clock edge after the read strobe and holds until the next read.

Software reads the 64-bit time as two words. A read of the low word also copies the current high word into a holding register. The following high-word read returns that copy, so both halves belong to the same instant, even if the low word wraps between the two reads. A 64-bit compare value, an enable bit and a sticky status flag make one event channel. The flag drives a level interrupt. To arm an event, software disables compare, writes the compare high word, writes the compare low word, and then enables compare. The event lead should be at least 100 ticks.

Top module: `usec_timer`

## Requirements
- R1: After a synchronous reset the timestamp equals the parameter TS_INIT (default 0). The compare value, the enable bit, the status flag, the high-word holding register and the read data are all zero.
- R2: The timestamp increments by exactly one every CLKS_PER_US system clocks and holds its value between those increments.
- R3: A read strobe loads the register at the given byte offset into the read data on the next edge. The offsets are 0x00 timestamp low, 0x04 held high word, 0x08 compare low, 0x0C compare high, 0x10 control and 0x14 status. Any other offset, including a misaligned one, returns zero. Without a read strobe the read data keeps its value.
- R4: A read of offset 0x00 copies the timestamp's upper 32 bits into the holding register on the same edge that captures the low word. A read of 0x04 returns the copy, so the two words form one coherent 64-bit value.
- R5: Writes to 0x08 and 0x0C set the low and high halves of the compare value independently. Each half reads back as written.
- R6: In the control register, bit 0 is compare enable and bit 1 qualifies it. A control write copies bit 0 into the enable only when bit 1 is 1 in the same write; otherwise the enable stays the same. A control read returns the enable in bit 0 and zero in every other bit.
- R7: On each tick edge where compare is enabled and the incremented timestamp is greater than or equal to the compare value (unsigned), status bit 0 is set. The flag stays set until software clears it.
- R8: Writing a 1 to status bit 0 at 0x14 clears the flag, and writing a 0 leaves it unchanged. If a clear and a set fall on the same edge, the set wins.
- R9: The irq output always equals status bit 0.
- R10: If the flag is cleared while compare is still enabled and the timestamp is still at or past the compare value, the flag sets again on the next tick.
- R11: While compare is disabled, the flag is never set, whatever the compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while the match flag is set |

## Verification
The bench builds the timer with CLKS_PER_US = 4. A 100-tick compare lead then takes only a few hundred clocks, so arming, matching, clearing and re-setting the flag all fit in a short run. It also sets TS_INIT = 0x0000_0000_FFFF_FF00. With that value the low word wraps into the high word about a thousand clocks after reset, so split reads spaced across the carry test the coherence of the held high word without billions of ticks.

// File: rtl/utm_pkg.sv
package utm_pkg;

    localparam int TS_W   = 64;
    localparam int WORD_W = 32;
    localparam int OFS_W  = 8;

    localparam logic [OFS_W-1:0] OFS_TS_LO  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_TS_HI  = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CMP_LO = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CMP_HI = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h10;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h14;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_QUAL_BIT = 1;
    localparam int STAT_FLAG_BIT = 0;

    typedef enum logic [2:0] {
        SEL_TS_LO,
        SEL_TS_HI,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_CTRL,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic snap;
        logic cmp_lo_wr;
        logic cmp_hi_wr;
        logic ctrl_wr;
        logic stat_wr;
    } strobe_t;

    function automatic reg_sel_e decode_offset(input logic [OFS_W-1:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_TS_LO:  sel = SEL_TS_LO;
            OFS_TS_HI:  sel = SEL_TS_HI;
            OFS_CMP_LO: sel = SEL_CMP_LO;
            OFS_CMP_HI: sel = SEL_CMP_HI;
            OFS_CTRL:   sel = SEL_CTRL;
            OFS_STAT:   sel = SEL_STAT;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    function automatic logic [WORD_W-1:0] flag_word(input logic b);
        logic [WORD_W-1:0] w;
        w = '0;
        w[0] = b;
        return w;
    endfunction

endpackage

// File: rtl/utm_tick_gen.sv
module utm_tick_gen #(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    generate
        if (CLKS_PER_US == 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_divide
            logic [PRE_W-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign tick = (pre_q == PRE_LAST);

            // R2: the tick enable lasts a single clock
            a_r2_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/utm_timestamp.sv
module utm_timestamp
    import utm_pkg::*;
#(
    parameter logic [TS_W-1:0] TS_INIT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              snap,
    output logic [TS_W-1:0]   count,
    output logic [TS_W-1:0]   count_next,
    output logic [WORD_W-1:0] held_hi
);
    localparam int HI_LSB = TS_W - WORD_W;

    logic [TS_W-1:0]   count_q;
    logic [WORD_W-1:0] held_q;

    assign count_next = tick ? count_q + 1'b1 : count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= TS_INIT;
            held_q  <= '0;
        end else begin
            count_q <= count_next;
            if (snap) begin
                held_q <= count_q[TS_W-1:HI_LSB];
            end
        end
    end

    assign count   = count_q;
    assign held_hi = held_q;

    // R2: one step per tick, frozen otherwise
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + 1'b1);
    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));
    // R4: low-word read captures the upper half of the same instant
    a_r4_hold_capture: assert property (@(posedge clk) disable iff (rst)
        snap |=> held_hi == $past(count[TS_W-1:HI_LSB]));
    a_r4_hold_keep: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(held_hi));

endmodule

// File: rtl/utm_compare.sv
module utm_compare
    import utm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [TS_W-1:0]   count_next,
    input  strobe_t           strb,
    input  logic [WORD_W-1:0] wdata,
    output logic [TS_W-1:0]   cmp_val,
    output logic              cmp_en,
    output logic              flag
);
    localparam int HI_LSB = TS_W - WORD_W;

    logic [TS_W-1:0] cmp_q;
    logic            en_q;
    logic            flag_q;
    logic            hit;
    logic            clr;

    assign hit = tick && en_q && (count_next >= cmp_q);
    assign clr = strb.stat_wr && wdata[STAT_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (strb.cmp_lo_wr) begin
                cmp_q[WORD_W-1:0] <= wdata;
            end
            if (strb.cmp_hi_wr) begin
                cmp_q[TS_W-1:HI_LSB] <= wdata;
            end
            if (strb.ctrl_wr && wdata[CTRL_QUAL_BIT]) begin
                en_q <= wdata[CTRL_EN_BIT];
            end
            if (hit) begin
                flag_q <= 1'b1;
            end else if (clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign cmp_val = cmp_q;
    assign cmp_en  = en_q;
    assign flag    = flag_q;

    // R6: an unqualified control write leaves the enable alone
    a_r6_en_guard: assert property (@(posedge clk) disable iff (rst)
        (strb.ctrl_wr && !wdata[CTRL_QUAL_BIT]) |=> $stable(cmp_en));
    // R7: the flag is sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    // R8: a clear with no coincident match drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag);
    // R11: the flag only rises on a tick while enabled
    a_r11_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(cmp_en) && $past(tick)));

endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import utm_pkg::*;
#(
    parameter int               CLKS_PER_US = 125,
    parameter int               ADDR_W      = 5,
    parameter logic [TS_W-1:0]  TS_INIT     = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int HI_LSB = TS_W - WORD_W;

    logic [OFS_W-1:0]  ofs;
    reg_sel_e          sel;
    strobe_t           strb;
    logic              tick;
    logic [TS_W-1:0]   count;
    logic [TS_W-1:0]   count_next;
    logic [WORD_W-1:0] held_hi;
    logic [TS_W-1:0]   cmp_val;
    logic              cmp_en;
    logic              flag;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    assign ofs = OFS_W'(bus_addr);
    assign sel = decode_offset(ofs);

    always_comb begin
        strb           = '0;
        strb.snap      = bus_rd && (sel == SEL_TS_LO);
        strb.cmp_lo_wr = bus_wr && (sel == SEL_CMP_LO);
        strb.cmp_hi_wr = bus_wr && (sel == SEL_CMP_HI);
        strb.ctrl_wr   = bus_wr && (sel == SEL_CTRL);
        strb.stat_wr   = bus_wr && (sel == SEL_STAT);
    end

    utm_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    utm_timestamp #(.TS_INIT(TS_INIT)) u_ts (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .snap       (strb.snap),
        .count      (count),
        .count_next (count_next),
        .held_hi    (held_hi)
    );

    utm_compare u_cmp (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .count_next (count_next),
        .strb       (strb),
        .wdata      (bus_wdata),
        .cmp_val    (cmp_val),
        .cmp_en     (cmp_en),
        .flag       (flag)
    );

    always_comb begin
        case (sel)
            SEL_TS_LO:  rd_mux = count[WORD_W-1:0];
            SEL_TS_HI:  rd_mux = held_hi;
            SEL_CMP_LO: rd_mux = cmp_val[WORD_W-1:0];
            SEL_CMP_HI: rd_mux = cmp_val[TS_W-1:HI_LSB];
            SEL_CTRL:   rd_mux = flag_word(cmp_en);
            SEL_STAT:   rd_mux = flag_word(flag);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = flag;

    // R3: unmapped offsets read as zero; idle bus keeps the data
    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
    // R6: control read has only the enable bit
    a_r6_ctrl_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_CTRL) |=> bus_rdata[WORD_W-1:1] == '0);

endmodule

// File: tb/tb_usec_timer.sv
module tb_usec_timer;

    localparam int          CPU     = 4;
    localparam int          AW      = 5;
    localparam logic [63:0] TS_INIT = 64'h0000_0000_FFFF_FF00;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usec_timer #(.CLKS_PER_US(CPU), .ADDR_W(AW), .TS_INIT(TS_INIT)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // behavioural reference
    int               m_pre;
    longint unsigned  m_ts, m_cmp;
    bit               m_en, m_st;
    logic [31:0]      m_hold, m_rdata;

    always @(posedge clk) begin
        bit tk, setc, clr;
        longint unsigned nts;
        if (rst) begin
            m_pre = 0; m_ts = TS_INIT; m_cmp = 0; m_en = 0; m_st = 0;
            m_hold = 0; m_rdata = 0;
        end else begin
            tk = (m_pre == CPU - 1);
            m_pre = tk ? 0 : m_pre + 1;
            nts = m_ts + (tk ? 1 : 0);
            setc = tk && m_en && (nts >= m_cmp);
            clr = bus_wr && bus_addr == 5'h14 && bus_wdata[0];
            if (bus_rd) begin
                case (bus_addr)
                    5'h00: begin m_rdata = m_ts[31:0]; m_hold = m_ts[63:32]; end
                    5'h04: m_rdata = m_hold;
                    5'h08: m_rdata = m_cmp[31:0];
                    5'h0C: m_rdata = m_cmp[63:32];
                    5'h10: m_rdata = {31'b0, m_en};
                    5'h14: m_rdata = {31'b0, m_st};
                    default: m_rdata = 0;
                endcase
            end
            if (bus_wr) begin
                case (bus_addr)
                    5'h08: m_cmp[31:0] = bus_wdata;
                    5'h0C: m_cmp[63:32] = bus_wdata;
                    5'h10: if (bus_wdata[1]) m_en = bus_wdata[0];
                    default: ;
                endcase
            end
            if (setc) m_st = 1;
            else if (clr) m_st = 0;
            m_ts = nts;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-clock comparison against the model (R3, R9)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 rdata vs model", {32'b0, bus_rdata}, {32'b0, m_rdata});
            check("R9 irq vs model", {63'b0, irq}, {63'b0, m_st});
        end
    end

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, lo, hi, t1, t2;
        longint unsigned prev, cur, arm;
        bit seen_carry;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rdata reset", {32'b0, bus_rdata}, 64'd0);
        check("R1 irq reset", {63'b0, irq}, 64'd0);
        bus_read(5'h04, d); check("R1 held high zero", {32'b0, d}, 64'd0);
        bus_read(5'h08, d); check("R1 cmp low zero", {32'b0, d}, 64'd0);
        bus_read(5'h0C, d); check("R1 cmp high zero", {32'b0, d}, 64'd0);
        bus_read(5'h10, d); check("R1 enable zero", {32'b0, d}, 64'd0);
        bus_read(5'h14, d); check("R1 status zero", {32'b0, d}, 64'd0);

        // R2: reads 40 clocks apart differ by exactly 10 ticks
        bus_read(5'h00, t1);
        repeat (39) @(posedge clk);
        bus_read(5'h00, t2);
        check("R2 tick rate", {32'b0, t2 - t1}, 64'd10);

        // R4: split reads across the low-word carry
        prev = 0; seen_carry = 0;
        for (int i = 0; i < 130; i++) begin
            bus_read(5'h00, lo);
            repeat (6) @(posedge clk);
            bus_read(5'h04, hi);
            cur = {hi, lo};
            check("R4 coherent pair", {32'b0, hi}, (lo >= 32'hFFFF_FF00) ? 64'd0 : 64'd1);
            if (cur < prev) check("R4 monotonic pair", cur, prev);
            if (hi == 1) seen_carry = 1;
            prev = cur;
        end
        check("R4 carry reached", {63'b0, seen_carry}, 64'd1);

        // R5: compare words
        bus_write(5'h0C, 32'h1234_5678);
        bus_write(5'h08, 32'h9ABC_DEF0);
        bus_read(5'h08, d); check("R5 cmp low", {32'b0, d}, 64'h9ABC_DEF0);
        bus_read(5'h0C, d); check("R5 cmp high", {32'b0, d}, 64'h1234_5678);

        // R6: qualified enable
        bus_write(5'h10, 32'h1);
        bus_read(5'h10, d); check("R6 unqualified set ignored", {32'b0, d}, 64'd0);
        bus_write(5'h10, 32'h3);
        bus_read(5'h10, d); check("R6 qualified set", {32'b0, d}, 64'd1);
        bus_write(5'h10, 32'hFFFF_FFFC);
        bus_read(5'h10, d); check("R6 unqualified clear ignored", {32'b0, d}, 64'd1);
        bus_write(5'h10, 32'h2);
        bus_read(5'h10, d); check("R6 qualified clear", {32'b0, d}, 64'd0);

        // R11: compare value in the past but disabled
        bus_write(5'h0C, 32'h0);
        bus_write(5'h08, 32'h0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check("R11 no irq while disabled", {63'b0, irq}, 64'd0);
        bus_read(5'h14, d); check("R11 status clear while disabled", {32'b0, d}, 64'd0);

        // R7: arm an event 100 ticks ahead
        bus_write(5'h10, 32'h2);
        bus_read(5'h00, lo);
        bus_read(5'h04, hi);
        arm = {hi, lo} + 100;
        bus_write(5'h0C, arm[63:32]);
        bus_write(5'h08, arm[31:0]);
        bus_write(5'h10, 32'h3);
        repeat (300) @(posedge clk);
        @(negedge clk);
        check("R7 no early match", {63'b0, irq}, 64'd0);
        repeat (200) @(posedge clk);
        @(negedge clk);
        check("R7 match raised irq", {63'b0, irq}, 64'd1);
        bus_read(5'h14, d); check("R7 status set", {32'b0, d}, 64'd1);

        // R8: writing zero does nothing
        bus_write(5'h14, 32'h0);
        bus_read(5'h14, d); check("R8 write zero ignored", {32'b0, d}, 64'd1);

        // R10: clear while still matching sets again on the next tick
        bus_write(5'h14, 32'h1);
        repeat (CPU + 1) @(posedge clk);
        @(negedge clk);
        check("R10 flag re-set", {63'b0, irq}, 64'd1);

        // R8: disable then clear
        bus_write(5'h10, 32'h2);
        bus_write(5'h14, 32'h1);
        check("R8 cleared", {63'b0, irq}, 64'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R8 stays clear", {63'b0, irq}, 64'd0);

        // R3: unmapped and misaligned offsets
        bus_read(5'h18, d); check("R3 unmapped 0x18", {32'b0, d}, 64'd0);
        bus_read(5'h08, d);
        bus_read(5'h02, d); check("R3 misaligned 0x02", {32'b0, d}, 64'd0);
        bus_read(5'h1C, d); check("R3 unmapped 0x1C", {32'b0, d}, 64'd0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R3 rdata holds", {32'b0, bus_rdata}, 64'd0);

        finish_run();
    end

endmodule